// File: doc/BRIEF.md
# Timebase Synchronization Sequencer

This block is a per-core sequencer that walks a core's timebase through the steps needed before it can be locked to a chip-level time-of-day (TOD) source. Software writes a control word with three request bits: load-mod, move-TOD-to-TB and clear-errors. The TOD unit answers with a sync pulse and a transfer-done indication. A timebase write strobe, with a select that marks a low-word write, reports software writes to the timebase itself.

The block reports the current state code and the code of the state it came from. It also drives a timebase-valid flag, a sticky firmware-control error flag, a ready-for-TOD handshake toward the TOD unit, and a sync-seen status bit. An accepted load-mod or move request arms a settle counter. While that counter is running, no sequencing step is taken. Conflicting or out-of-order requests park the machine in an error state. Only a clear-errors request leaves that state.

State codes: 0 reset, 1 send-mod, 2 not-set, 6 sync-wait, 7 get-TOD, 8 running, 9 error.

Top module: `tbsync_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to state 0 with last-state 0. The flags `tb_valid`, `fw_err`, `tod_ready` and `sync_seen` are all 0.
- R2: `state_code` only ever holds 0, 1, 2, 6, 7, 8 or 9. Codes 3, 4 and 5 never appear.
- R3: Whenever `state_code` changes, `last_code` takes the previous state code. The one exception is a completed load-mod step: it passes through send-mod without stopping, so it leaves `last_code` = 1 and `state_code` = 2.
- R4: `tb_valid` is 1 exactly in the cycles where `state_code` is 8.
- R5: A load-mod write accepted in state 0, 2, 6 or 8 starts the settle counter. The state does not change for 3 edges. On the 4th edge after the write, the state becomes 2, `last_code` becomes 1, and `tod_ready` goes to 0.
- R6: A load-mod request that completes while the state is 7 moves the machine to state 9 and sets `fw_err`.
- R7: A move write in state 2 moves to state 6 and raises `tod_ready`. A move write in state 0, 1 or 8 moves to state 9, sets `fw_err` and drops `tod_ready`.
- R8: In state 6, a sync pulse is ignored during the 3 edges after the move write. Once the settle counter has expired, a sync pulse moves the state to 7. In state 7, transfer-done moves the state to 8 and drops `tod_ready`.
- R9: A control write with load-mod and move both set moves to state 9, sets `fw_err` and drops `tod_ready`, whatever the current state.
- R10: A clear-errors write without the load-mod and move conflict moves to state 0. It clears `fw_err`, `tod_ready` and any pending load-mod request.
- R11: In state 9, any control write other than clear-errors or the conflict leaves the state at 9 and sets `fw_err`.
- R12: A low-word timebase write (`tb_wr`=1, `tb_wr_low`=1) in state 8 moves the machine to state 9. A high-word write (`tb_wr_low`=0) in state 8, and a low-word write in any other state, leave the state unchanged.
- R13: Every control write clears `sync_seen` at that edge. `sync_seen` stays 0 for the next edge as well and returns to 1 on the second edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_load_mod | input | 1 | Load-mod request bit of the written word |
| ctl_move_tod | input | 1 | Move-TOD-to-TB request bit of the written word |
| ctl_clear_err | input | 1 | Clear-errors request bit of the written word |
| tod_sync_pulse | input | 1 | Sync pulse from the TOD unit |
| tod_xfer_done | input | 1 | TOD value has been transferred to the timebase |
| tb_wr | input | 1 | Software write to the timebase |
| tb_wr_low | input | 1 | With `tb_wr`: 1 = low word, 0 = high word |
| state_code | output | 4 | Current state code |
| last_code | output | 4 | Previous state code |
| tb_valid | output | 1 | Timebase valid (state 8) |
| fw_err | output | 1 | Sticky firmware-control error |
| tod_ready | output | 1 | Ready-for-TOD handshake |
| sync_seen | output | 1 | Sync-occurred status |

## Verification
The assertions assume that each input is a registered, single-bit strobe that is 0 or 1 at every edge after reset. They also assume that the TOD unit only answers with a sync pulse or a transfer-done after `tod_ready` has gone high. The bench drives every input on the falling edge and returns it to 0 after the rising edge that consumes it. It raises the TOD-side inputs only in the sequence the requirements describe. The one exception is a sync pulse held high during the settle window, which is done on purpose to show that the pulse is ignored there.

// File: rtl/tbsync_pkg.sv
package tbsync_pkg;

    localparam int unsigned CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        TS_RESET    = 4'd0,
        TS_SENDMOD  = 4'd1,
        TS_NOTSET   = 4'd2,
        TS_SYNCWAIT = 4'd6,
        TS_GETTOD   = 4'd7,
        TS_RUN      = 4'd8,
        TS_ERROR    = 4'd9
    } tbs_e;

    typedef struct packed {
        logic load_mod;
        logic move_tod;
        logic clear_err;
    } ctl_word_t;

    // States from which a completed load-mod step is legal
    function automatic logic load_ok(input tbs_e s);
        return (s == TS_RESET) || (s == TS_NOTSET) ||
               (s == TS_SYNCWAIT) || (s == TS_RUN);
    endfunction

    // States in which a repeated move request is tolerated
    function automatic logic move_hold(input tbs_e s);
        return (s == TS_SYNCWAIT) || (s == TS_GETTOD);
    endfunction

endpackage

// File: rtl/tbsync_settle.sv
module tbsync_settle #(
    parameter int unsigned SETTLE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic busy
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_V;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/tbsync_pulse.sv
module tbsync_pulse #(
    parameter int unsigned DELAY_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    output logic seen
);
    localparam int unsigned DW = $clog2(DELAY_CYCLES + 1);
    localparam logic [DW-1:0] LOAD_V = DW'(DELAY_CYCLES);

    logic [DW-1:0] dly_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q  <= '0;
            seen_q <= 1'b0;
        end else if (wr) begin
            dly_q  <= LOAD_V;
            seen_q <= 1'b0;
        end else if (dly_q != '0) begin
            dly_q  <= dly_q - 1'b1;
        end else begin
            seen_q <= 1'b1;
        end
    end

    assign seen = seen_q;
endmodule

// File: rtl/tbsync_fsm.sv
module tbsync_fsm
    import tbsync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr,
    input  ctl_word_t ctl,
    input  logic      sync_pulse,
    input  logic      xfer_done,
    input  logic      tb_wr,
    input  logic      tb_wr_low,
    input  logic      settle_busy,
    output logic      settle_start,
    output logic      settle_cancel,
    output tbs_e      state,
    output tbs_e      last,
    output logic      valid,
    output logic      fw_err,
    output logic      ready
);
    tbs_e st_q, st_n, last_q, last_n;
    logic fw_q, fw_n, rdy_q, rdy_n, ld_q, ld_n, val_q;

    always_comb begin
        st_n          = st_q;
        last_n        = last_q;
        fw_n          = fw_q;
        rdy_n         = rdy_q;
        ld_n          = ld_q;
        settle_start  = 1'b0;
        settle_cancel = 1'b0;

        if (ctl_wr) begin
            if (ctl.load_mod && ctl.move_tod) begin
                last_n        = st_q;
                st_n          = TS_ERROR;
                fw_n          = 1'b1;
                rdy_n         = 1'b0;
                ld_n          = 1'b0;
                settle_cancel = 1'b1;
            end else if (ctl.clear_err) begin
                last_n        = st_q;
                st_n          = TS_RESET;
                fw_n          = 1'b0;
                rdy_n         = 1'b0;
                ld_n          = 1'b0;
                settle_cancel = 1'b1;
            end else if (st_q == TS_ERROR) begin
                fw_n = 1'b1;
            end else if (ctl.load_mod) begin
                ld_n         = 1'b1;
                settle_start = 1'b1;
            end else if (ctl.move_tod) begin
                ld_n = 1'b0;
                if (st_q == TS_NOTSET) begin
                    last_n       = st_q;
                    st_n         = TS_SYNCWAIT;
                    rdy_n        = 1'b1;
                    settle_start = 1'b1;
                end else if (!move_hold(st_q)) begin
                    last_n        = st_q;
                    st_n          = TS_ERROR;
                    fw_n          = 1'b1;
                    rdy_n         = 1'b0;
                    settle_cancel = 1'b1;
                end
            end else begin
                ld_n = 1'b0;
            end
        end else if (tb_wr && tb_wr_low && st_q == TS_RUN) begin
            last_n        = st_q;
            st_n          = TS_ERROR;
            ld_n          = 1'b0;
            settle_cancel = 1'b1;
        end else if (!settle_busy && st_q != TS_ERROR) begin
            if (ld_q) begin
                ld_n  = 1'b0;
                rdy_n = 1'b0;
                if (load_ok(st_q)) begin
                    // passes through send-mod without stopping
                    last_n = TS_SENDMOD;
                    st_n   = TS_NOTSET;
                end else begin
                    last_n = st_q;
                    st_n   = TS_ERROR;
                    fw_n   = 1'b1;
                end
            end else if (st_q == TS_SYNCWAIT && sync_pulse) begin
                last_n = st_q;
                st_n   = TS_GETTOD;
            end else if (st_q == TS_GETTOD && xfer_done) begin
                last_n = st_q;
                st_n   = TS_RUN;
                rdy_n  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TS_RESET;
            last_q <= TS_RESET;
            fw_q   <= 1'b0;
            rdy_q  <= 1'b0;
            ld_q   <= 1'b0;
            val_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            last_q <= last_n;
            fw_q   <= fw_n;
            rdy_q  <= rdy_n;
            ld_q   <= ld_n;
            val_q  <= (st_n == TS_RUN);
        end
    end

    assign state  = st_q;
    assign last   = last_q;
    assign valid  = val_q;
    assign fw_err = fw_q;
    assign ready  = rdy_q;
endmodule

// File: rtl/tbsync_ctrl.sv
module tbsync_ctrl
    import tbsync_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 3,
    parameter int unsigned SYNC_DELAY    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_load_mod,
    input  logic              ctl_move_tod,
    input  logic              ctl_clear_err,
    input  logic              tod_sync_pulse,
    input  logic              tod_xfer_done,
    input  logic              tb_wr,
    input  logic              tb_wr_low,
    output logic [CODE_W-1:0] state_code,
    output logic [CODE_W-1:0] last_code,
    output logic              tb_valid,
    output logic              fw_err,
    output logic              tod_ready,
    output logic              sync_seen
);
    ctl_word_t ctl;
    logic      busy, start, cancel;
    tbs_e      st, lst;

    assign ctl = '{load_mod: ctl_load_mod, move_tod: ctl_move_tod,
                   clear_err: ctl_clear_err};

    tbsync_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst(rst), .start(start), .cancel(cancel), .busy(busy)
    );

    tbsync_pulse #(.DELAY_CYCLES(SYNC_DELAY)) u_pulse (
        .clk(clk), .rst(rst), .wr(ctl_wr), .seen(sync_seen)
    );

    tbsync_fsm u_fsm (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl(ctl),
        .sync_pulse(tod_sync_pulse), .xfer_done(tod_xfer_done),
        .tb_wr(tb_wr), .tb_wr_low(tb_wr_low), .settle_busy(busy),
        .settle_start(start), .settle_cancel(cancel),
        .state(st), .last(lst), .valid(tb_valid), .fw_err(fw_err),
        .ready(tod_ready)
    );

    assign state_code = st;
    assign last_code  = lst;
endmodule

// File: rtl/tbsync_ctrl_chk.sv
module tbsync_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic       ctl_load_mod,
    input logic       ctl_move_tod,
    input logic       ctl_clear_err,
    input logic       tod_sync_pulse,
    input logic [3:0] state_code,
    input logic [3:0] last_code,
    input logic       tb_valid,
    input logic       fw_err,
    input logic       tod_ready,
    input logic       sync_seen
);
    p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
        (state_code inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7, 4'd8, 4'd9}));

    p_history_r3: assert property (@(posedge clk) disable iff (rst)
        (state_code != $past(state_code) &&
         !(state_code == 4'd2 && last_code == 4'd1))
        |-> last_code == $past(state_code));

    p_valid_run_r4: assert property (@(posedge clk) disable iff (rst)
        tb_valid == (state_code == 4'd8));

    p_ready_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tod_ready) |-> state_code == 4'd6);

    p_sync_advance_r8: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd7 && $past(state_code) == 4'd6)
        |-> $past(tod_sync_pulse));

    p_conflict_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_load_mod && ctl_move_tod)
        |=> (state_code == 4'd9 && fw_err && !tod_ready));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_clear_err && !(ctl_load_mod && ctl_move_tod))
        |=> (state_code == 4'd0 && !fw_err && !tod_ready));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd9 && ctl_wr && !ctl_clear_err)
        |=> (state_code == 4'd9 && fw_err));

    p_sync_clear_r13: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> !sync_seen);
endmodule

bind tbsync_ctrl tbsync_ctrl_chk u_chk (.*);

// File: tb/tb_tbsync_ctrl.sv
module tb_tbsync_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst, ctl_wr, ld, mv, clr, syncp, xfer, tbw, tblow;
    logic [3:0] st, lst;
    logic valid, ferr, rdy, sseen;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbsync_ctrl dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_load_mod(ld),
        .ctl_move_tod(mv), .ctl_clear_err(clr), .tod_sync_pulse(syncp),
        .tod_xfer_done(xfer), .tb_wr(tbw), .tb_wr_low(tblow),
        .state_code(st), .last_code(lst), .tb_valid(valid),
        .fw_err(ferr), .tod_ready(rdy), .sync_seen(sseen)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic l, input logic m, input logic c);
        @(negedge clk);
        ctl_wr = 1'b1; ld = l; mv = m; clr = c;
        @(posedge clk); #1;
        ctl_wr = 1'b0; ld = 1'b0; mv = 1'b0; clr = 1'b0;
    endtask

    task automatic pulse_in(input int which);
        @(negedge clk);
        if (which == 0) syncp = 1'b1;
        else if (which == 1) xfer = 1'b1;
        else begin tbw = 1'b1; tblow = (which == 2); end
        @(posedge clk); #1;
        syncp = 1'b0; xfer = 1'b0; tbw = 1'b0; tblow = 1'b0;
    endtask

    // helper: from reset to not-set, no checks
    task automatic to_notset();
        wr(1'b0, 1'b0, 1'b1);
        wr(1'b1, 1'b0, 1'b0);
        tick(4);
    endtask

    task automatic to_gettod();
        to_notset();
        wr(1'b0, 1'b1, 1'b0);
        tick(3);
        pulse_in(0);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        tick(2);
        chk("R1 state", st, 0);
        chk("R1 last", lst, 0);
        chk("R1 valid", valid, 0);
        chk("R1 fw_err", ferr, 0);
        chk("R1 ready", rdy, 0);
        chk("R1 sync_seen", sseen, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_bringup();
        wr(1'b1, 1'b0, 1'b0);
        tick(3);
        chk("R5 settle holds", st, 0);
        tick(1);
        chk("R5 state", st, 2);
        chk("R3/R5 last via send-mod", lst, 1);
        wr(1'b0, 1'b1, 1'b0);
        chk("R7 state", st, 6);
        chk("R7 ready", rdy, 1);
        chk("R3 last", lst, 2);
        @(negedge clk); syncp = 1'b1;
        tick(3);
        chk("R8 pulse ignored while settling", st, 6);
        tick(1);
        syncp = 1'b0;
        chk("R8 sync advance", st, 7);
        chk("R3 last", lst, 6);
        pulse_in(1);
        chk("R8 running", st, 8);
        chk("R8 ready dropped", rdy, 0);
        chk("R4 valid", valid, 1);
    endtask

    task automatic t_tb_writes();
        pulse_in(3);
        chk("R12 high-word no change", st, 8);
        pulse_in(2);
        chk("R12 low-word error", st, 9);
        chk("R4 valid drop", valid, 0);
        chk("R3 last", lst, 8);
        to_notset();
        pulse_in(2);
        chk("R12 low-word outside running", st, 2);
    endtask

    task automatic t_error_write();
        wr(1'b1, 1'b1, 1'b0);
        chk("R9 conflict state", st, 9);
        chk("R9 fw_err", ferr, 1);
        wr(1'b1, 1'b0, 1'b0);
        chk("R11 stays error", st, 9);
        chk("R11 fw_err", ferr, 1);
        tick(5);
        chk("R11 load ignored", st, 9);
        wr(1'b0, 1'b0, 1'b1);
        chk("R10 clear state", st, 0);
        chk("R10 fw_err clear", ferr, 0);
        chk("R3 last", lst, 9);
    endtask

    task automatic t_move_bad();
        wr(1'b0, 1'b1, 1'b0);
        chk("R7 move from reset", st, 9);
        chk("R7 fw_err", ferr, 1);
        chk("R7 ready", rdy, 0);
        to_notset();
        wr(1'b0, 1'b1, 1'b0);
        wr(1'b1, 1'b1, 1'b0);
        chk("R9 conflict drops ready", rdy, 0);
        chk("R9 state", st, 9);
    endtask

    task automatic t_load_gettod();
        to_gettod();
        chk("R8 in get-tod", st, 7);
        wr(1'b1, 1'b0, 1'b0);
        tick(3);
        chk("R6 settle holds", st, 7);
        tick(1);
        chk("R6 error", st, 9);
        chk("R6 fw_err", ferr, 1);
        chk("R6 last", lst, 7);
    endtask

    task automatic t_load_running();
        to_gettod();
        pulse_in(1);
        wr(1'b1, 1'b0, 1'b0);
        tick(4);
        chk("R5 from running", st, 2);
        chk("R5 last", lst, 1);
        chk("R4 valid off", valid, 0);
        chk("R5 ready", rdy, 0);
    endtask

    task automatic t_sync_seen();
        tick(3);
        chk("R13 idle high", sseen, 1);
        wr(1'b0, 1'b0, 1'b0);
        chk("R13 cleared", sseen, 0);
        tick(1);
        chk("R13 still low", sseen, 0);
        tick(1);
        chk("R13 back", sseen, 1);
    endtask

    initial begin
        rst = 1'b1; ctl_wr = 1'b0; ld = 1'b0; mv = 1'b0; clr = 1'b0;
        syncp = 1'b0; xfer = 1'b0; tbw = 1'b0; tblow = 1'b0;
        t_reset();
        t_bringup();
        t_tb_writes();
        t_error_write();
        t_move_bad();
        wr(1'b0, 1'b0, 1'b1);
        t_load_gettod();
        wr(1'b0, 1'b0, 1'b1);
        t_load_running();
        t_sync_seen();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule